// File: doc/BRIEF.md
# Register-mapped watchdog timer core

This core is a watchdog peripheral reached over a narrow byte-wide register bus that has a write enable, a read strobe, an 8-bit address and 8-bit data. Host software arms it by writing a run command. It then counts down a programmable number of seconds, derived from an external 1 ms tick, and the host restarts the countdown by writing a ping. If the count runs out, the core drives a reset output for a programmable number of milliseconds. It also records that the watchdog caused that reset, so software can read the cause after the system comes back up.

The core has three run states: unconfigured (0), stopped (1) and running (2). It comes out of power-on reset unconfigured and counts only while running. The firmware and bootloader version registers are fixed read-only constants set by parameters.

Top module: `wdt_regcore`

## Requirements
- R1: After reset the core reads state 0, timeout 30, pulse width 100, reset cause 0 and seconds remaining 0, and rst_out is low.
- R2: A read with bus_re high returns data on bus_rdata one cycle later. Address map: 0x01/0x02 firmware major/minor, 0x03/0x04 bootloader major/minor (parameters), 0x05 cause, 0x06 state, 0x07 timeout, 0x08 seconds remaining, 0x0A pulse width. Any other address reads 0.
- R3: A write to 0x07 with a value of 3 to 255 sets the timeout. A write of 0, 1 or 2 is ignored and the old value stays.
- R4: A write to 0x0A with a value of 1 to 255 sets the pulse width in ms. A write of 0 is ignored.
- R5: Writing 2 to 0x06 reloads seconds remaining from the timeout, clears the prescaler and enters running. Writing 1 enters stopped and freezes seconds remaining. Any other value is ignored.
- R6: While running, seconds remaining drops by one for every TICKS_PER_SEC cycles in which tick_ms is high. Cycles with tick_ms low do not count.
- R7: Writing 0x00 to 0x09 reloads seconds remaining from the timeout and clears the prescaler. A write of any other value to 0x09 has no effect on the countdown.
- R8: When seconds remaining reaches 0 while running, the core sets the cause to 1 and the state to 0 in the same edge that raises rst_out. rst_out then stays high for exactly the programmed number of tick_ms cycles.
- R9: A ping or a state write in the same cycle as the final seconds step takes priority, and no expiry occurs.
- R10: The cause value 1 survives the end of the pulse. Only a power-on reset returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick_ms | input | 1 | One-cycle 1 ms tick strobe |
| bus_we | input | 1 | Register write enable |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_re |
| rst_out | output | 1 | Active-high watchdog reset pulse |

## Verification
The key collision is a host ping, or a host state write, that lands in the same clock edge as the seconds step that would take the count to zero. The bench arms the core, counts exactly the number of cycles until the final step is due, and places the ping write on that edge. A correct core keeps rst_out low, reloads the count, and expires a full timeout after the ping. A design that lets the countdown win instead would raise the reset or show an early expiry.

// File: rtl/wdt_regcore.sv
module wdt_regcore #(
  parameter int TICKS_PER_SEC = 1000,
  parameter int TO_MIN        = 3,
  parameter int TO_DEFAULT    = 30,
  parameter int PW_DEFAULT    = 100,
  parameter logic [7:0] FW_MAJOR = 8'h01,
  parameter logic [7:0] FW_MINOR = 8'h07,
  parameter logic [7:0] BL_MAJOR = 8'h03,
  parameter logic [7:0] BL_MINOR = 8'h02
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       bus_we,
  input  logic       bus_re,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       rst_out
);
  localparam int PSW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PSW-1:0] PS_LAST = PSW'(TICKS_PER_SEC - 1);

  localparam logic [7:0] A_FWMAJ = 8'h01, A_FWMIN = 8'h02, A_BLMAJ = 8'h03,
                         A_BLMIN = 8'h04, A_CAUSE = 8'h05, A_STATE = 8'h06,
                         A_TMO   = 8'h07, A_LEFT  = 8'h08, A_PING  = 8'h09,
                         A_PULSE = 8'h0A;

  localparam logic [1:0] ST_INIT = 2'd0, ST_STOP = 2'd1, ST_RUN = 2'd2;
  localparam logic [7:0] CAUSE_POR = 8'd0, CAUSE_WDT = 8'd1;

  logic [1:0]     st_q;
  logic [7:0]     tmo_q, pw_q, left_q, pcnt_q, cause_q;
  logic [PSW-1:0] ps_q;

  wire wr_state = bus_we && bus_addr == A_STATE;
  wire wr_tmo   = bus_we && bus_addr == A_TMO;
  wire wr_pulse = bus_we && bus_addr == A_PULSE;
  wire wr_ping  = bus_we && bus_addr == A_PING;
  wire do_start = wr_state && bus_wdata == 8'd2;
  wire do_stop  = wr_state && bus_wdata == 8'd1;
  wire do_ping  = wr_ping && bus_wdata == 8'd0;
  wire counting = st_q == ST_RUN && !rst_out && tick_ms;
  wire sec_step = counting && ps_q == PS_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_INIT;
      tmo_q   <= 8'(TO_DEFAULT);
      pw_q    <= 8'(PW_DEFAULT);
      left_q  <= 8'd0;
      pcnt_q  <= 8'd0;
      cause_q <= CAUSE_POR;
      ps_q    <= '0;
      rst_out <= 1'b0;
    end else begin
      if (rst_out && tick_ms) begin
        pcnt_q <= pcnt_q - 8'd1;
        if (pcnt_q == 8'd1) rst_out <= 1'b0;
      end
      if (wr_tmo && bus_wdata >= 8'(TO_MIN)) tmo_q <= bus_wdata;
      if (wr_pulse && bus_wdata != 8'd0) pw_q <= bus_wdata;
      if (do_start) begin
        st_q   <= ST_RUN;
        left_q <= tmo_q;
        ps_q   <= '0;
      end else if (do_stop) begin
        st_q <= ST_STOP;
      end else if (do_ping) begin
        left_q <= tmo_q;
        ps_q   <= '0;
      end else if (counting) begin
        if (sec_step) begin
          ps_q <= '0;
          if (left_q <= 8'd1) begin
            left_q  <= 8'd0;
            st_q    <= ST_INIT;
            rst_out <= 1'b1;
            pcnt_q  <= pw_q;
            cause_q <= CAUSE_WDT;
          end else begin
            left_q <= left_q - 8'd1;
          end
        end else begin
          ps_q <= ps_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= 8'd0;
    else if (bus_re) begin
      case (bus_addr)
        A_FWMAJ: bus_rdata <= FW_MAJOR;
        A_FWMIN: bus_rdata <= FW_MINOR;
        A_BLMAJ: bus_rdata <= BL_MAJOR;
        A_BLMIN: bus_rdata <= BL_MINOR;
        A_CAUSE: bus_rdata <= cause_q;
        A_STATE: bus_rdata <= {6'd0, st_q};
        A_TMO:   bus_rdata <= tmo_q;
        A_LEFT:  bus_rdata <= left_q;
        A_PULSE: bus_rdata <= pw_q;
        default: bus_rdata <= 8'd0;
      endcase
    end
  end

  a_r3_timeout_range: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q >= 8'(TO_MIN));
  a_r4_pulse_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    pw_q != 8'd0);
  a_r5_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != 2'd3);
  a_r5_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STOP && !bus_we) |=> $stable(left_q));
  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> (left_q == $past(left_q) || left_q == $past(left_q) - 8'd1));
  a_r7_ping_reload: assert property (@(posedge clk) disable iff (!rst_n)
    do_ping |=> left_q == $past(tmo_q) && !$rose(rst_out));
  a_r8_cause_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> cause_q == CAUSE_WDT && st_q == ST_INIT);
  a_r10_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cause_q == CAUSE_WDT |=> cause_q == CAUSE_WDT);
endmodule

// File: tb/wdt_regcore_tb.sv
module wdt_regcore_tb_top;
  localparam int TPS = 10;
  logic clk = 1'b0, rst_n = 1'b0, tick_ms = 1'b1;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0] bus_addr = 8'd0, bus_wdata = 8'd0, bus_rdata;
  logic rst_out;
  int checks = 0, errors = 0;
  int cur_to = 30;

  always #2 clk = ~clk;

  wdt_regcore #(.TICKS_PER_SEC(TPS)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .bus_we(bus_we),
    .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_out(rst_out));

  function automatic int exp_to(int old_v, int new_v);
    return (new_v >= 3 && new_v <= 255) ? new_v : old_v;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output int v);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    v = int'(bus_rdata);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic meas_rise(output int n);
    n = 0;
    while (!rst_out && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic meas_width(output int n);
    n = 0;
    while (rst_out && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int v, k, w, tt, pp, bad, m;
    void'($urandom(32'd20240));
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    rd(8'h06, v); check("R1 state", v, 0);
    rd(8'h07, v); check("R1 timeout", v, 30);
    rd(8'h0A, v); check("R1 pulse", v, 100);
    rd(8'h05, v); check("R1 cause", v, 0);
    rd(8'h08, v); check("R1 left", v, 0);
    check("R1 rst_out", int'(rst_out), 0);

    rd(8'h01, v); check("R2 fw major", v, 1);
    rd(8'h02, v); check("R2 fw minor", v, 7);
    rd(8'h03, v); check("R2 bl major", v, 3);
    rd(8'h04, v); check("R2 bl minor", v, 2);
    rd(8'h20, v); check("R2 unmapped", v, 0);
    rd(8'h09, v); check("R2 ping reads 0", v, 0);

    wr(8'h07, 8'd2);   cur_to = exp_to(cur_to, 2);   rd(8'h07, v); check("R3 reject 2", v, cur_to);
    wr(8'h07, 8'd3);   cur_to = exp_to(cur_to, 3);   rd(8'h07, v); check("R3 accept 3", v, cur_to);
    wr(8'h07, 8'd255); cur_to = exp_to(cur_to, 255); rd(8'h07, v); check("R3 accept 255", v, cur_to);
    wr(8'h07, 8'd0);   cur_to = exp_to(cur_to, 0);   rd(8'h07, v); check("R3 reject 0", v, cur_to);

    wr(8'h0A, 8'd0); rd(8'h0A, v); check("R4 reject 0", v, 100);
    wr(8'h0A, 8'd1); rd(8'h0A, v); check("R4 accept 1", v, 1);

    wr(8'h07, 8'd5); cur_to = 5;
    wr(8'h06, 8'd2);
    wait_cyc(25);
    wr(8'h06, 8'd1);
    rd(8'h08, v); check("R5 stop keeps count", v, 3);
    wait_cyc(50);
    rd(8'h08, v); check("R5 frozen while stopped", v, 3);
    wr(8'h06, 8'd3);
    rd(8'h06, v); check("R5 illegal state ignored", v, 1);

    wr(8'h06, 8'd2);
    tick_ms = 1'b0;
    wait_cyc(40);
    rd(8'h08, v); check("R6 no tick no count", v, 5);
    rd(8'h06, v); check("R5 running", v, 2);
    tick_ms = 1'b1;

    wr(8'h09, 8'd0);
    wait_cyc(6);
    wr(8'h09, 8'd0);
    meas_rise(k); check("R7 ping clears prescaler", k, 10 * 5);
    meas_width(w); check("R8 width 1 ms", w, 1);
    rd(8'h06, v); check("R8 state to 0", v, 0);
    rd(8'h05, v); check("R8 cause wdt", v, 1);
    rd(8'h08, v); check("R8 left 0", v, 0);

    wr(8'h0A, 8'd4);
    wr(8'h06, 8'd2);
    wait_cyc(49);
    wr(8'h09, 8'd0);
    check("R9 ping wins over expiry", int'(rst_out), 0);
    meas_rise(k); check("R9 full timeout after ping", k, 50);
    meas_width(w); check("R8 width 4 ms", w, 4);
    rd(8'h05, v); check("R10 cause after pulse", v, 1);

    wr(8'h06, 8'd2);
    wait_cyc(49);
    wr(8'h06, 8'd1);
    wait_cyc(3);
    check("R9 stop wins over expiry", int'(rst_out), 0);
    rd(8'h08, v); check("R9 count held at 1", v, 1);

    for (int i = 0; i < 6; i++) begin
      tt  = 3 + int'($urandom % 6);
      pp  = 1 + int'($urandom % 12);
      bad = int'($urandom % 3);
      wr(8'h07, 8'(bad)); cur_to = exp_to(cur_to, bad);
      rd(8'h07, v); check("R3 random reject", v, cur_to);
      wr(8'h07, 8'(tt)); cur_to = exp_to(cur_to, tt);
      wr(8'h0A, 8'(pp));
      wr(8'h06, 8'd2);
      m = int'($urandom % (10 * tt - 2));
      wait_cyc(m);
      wr(8'h09, 8'h55);
      meas_rise(k); check("R7 nonzero ping ignored", m + 1 + k, 10 * cur_to);
      meas_width(w); check("R8 random width", w, pp);
      rd(8'h05, v); check("R10 random cause", v, 1);
    end

    summary();
    $finish;
  end
endmodule